// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits on the transmit path between a frame buffer and the MAC. It takes in a byte stream carrying one frame at a time, marked with start and end flags. When three flags are all set, it computes a 16-bit ones-complement checksum over part of the frame and writes the result into the frame. The three flags are a global engine enable, a first-segment flag and a per-packet checksum request. All other frames pass through byte for byte.

When the checksum operation is selected, the first four stream bytes form a control word and are not forwarded. This word carries two 12-bit byte offsets. One marks where summing starts and the other marks where the result is written. Summing always runs from the start offset to the last byte of the frame, and the result may be placed before or after the summed range. For that reason the block holds the whole frame in a local store before any byte leaves. The store is sized for block RAM inference.

If the frame already holds a partial checksum, the upper layer can include it in the sum by choosing a start offset that covers it. Pointing the insert offset at that partial value replaces it with the final result. An offset that falls inside the 14-byte link header or the 4-byte tail aborts the patch, and the block raises an error pulse.

Top module: `txcsum_insert`

## Requirements
- R1: After reset, `out_valid` and `err` are low and `in_ready` is high.
- R2: A frame whose `in_csum_req` is low at its start byte is emitted unchanged, byte for byte, even when `cfg_enable` is high. Its first four bytes are frame data, not a control word.
- R3: A frame with `cfg_enable` low, or with `in_first_seg` low at its start byte, is emitted unchanged, with no control word removed.
- R4: When all three flags are high at the start byte, the first four accepted bytes form the control word, with the first byte holding bits 7:0 and the fourth byte holding bits 31:24. These four bytes are never emitted. Bits 15:12 and 31:28 have no effect.
- R5: The control word's bits 11:0 give the start offset S, counted in bytes from the first frame byte after the control word. The sum covers frame bytes S through the last byte, taken as 16-bit words in which the first byte of each pair is the upper half. An odd final byte is padded with a zero lower half. Each addition folds its carry back into bit 0.
- R6: Bits 27:16 give the insert offset L. The bitwise inverse of the folded sum is written at byte L (upper 8 bits) and byte L+1 (lower 8 bits). All other bytes are unchanged, and L may lie before S.
- R7: The sum uses the frame bytes as received, including any bytes at L and L+1 that lie in the summed range. A partial checksum stored there is therefore included in the sum and then replaced.
- R8: For a frame of N bytes, the patch is applied only if S ≥ 14, S ≤ N−5, L ≥ 14 and L+1 ≤ N−5. Otherwise the frame is emitted unchanged and `err` is high for exactly one cycle.
- R9: No byte of a frame is emitted before its last input byte is accepted. `in_ready` drops in the cycle after that byte is accepted and stays low until emission has been issued. Output bytes leave in consecutive cycles, with `out_sop` on the first byte, `out_eop` on the last, and at least one idle cycle after each frame.
- R10: Frames of up to MAX_BYTES bytes (2048 by default), not counting the control word, are handled, including at full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global checksum engine enable |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet (control word or frame) |
| in_eop | input | 1 | Last byte of the frame |
| in_first_seg | input | 1 | Packet's first-segment flag, sampled with the start byte |
| in_csum_req | input | 1 | Packet's checksum request flag, sampled with the start byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of a frame |
| out_eop | output | 1 | Last output byte of a frame |
| err | output | 1 | One-cycle pulse when an offset breaks the header/tail rule |

## Verification
The assertions check the framing of the output stream on every cycle. Emission has no gaps, start and end markers sit inside valid bytes, and a frame is followed by an idle cycle. They also check that the error indication lasts one cycle, that input is refused right after a frame's last byte, and that the reset state is correct. Whether the right bytes come out can only be shown by the bench scenarios. These cover correct pass-through under each flag combination, removal of the control word, the checksum value for odd and even ranges, inclusion of a partial checksum, insertion ahead of the summed range, and the offset limits at both ends of the frame. The bench compares every output byte against a behavioural model and checks one checksum computed by hand.

// File: rtl/txcsum_pkg.sv
package txcsum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_LOAD,
    ST_CHECK,
    ST_EMIT
  } txcsum_state_e;

  localparam int HDR_BYTES  = 14;
  localparam int TAIL_BYTES = 4;
  localparam int OFS_BITS   = 12;
endpackage

// File: rtl/txcsum_store.sv
module txcsum_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txcsum_accum.sv
module txcsum_accum (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        add,
  input  logic        upper,
  input  logic [7:0]  byte_in,
  output logic [15:0] sum
);
  logic [16:0] raw;

  always_comb begin
    raw = {1'b0, sum} + (upper ? {1'b0, byte_in, 8'h00} : {9'b0, byte_in});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add)   sum <= raw[15:0] + {15'b0, raw[16]};
  end
endmodule

// File: rtl/txcsum_outstage.sv
module txcsum_outstage (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_v,
  input  logic        rd_first,
  input  logic        rd_last,
  input  logic        rd_hi,
  input  logic        rd_lo,
  input  logic [7:0]  rdata,
  input  logic [15:0] pval,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_v;
      out_sop   <= rd_v && rd_first;
      out_eop   <= rd_v && rd_last;
      if (rd_hi)      out_data <= pval[15:8];
      else if (rd_lo) out_data <= pval[7:0];
      else            out_data <= rdata;
    end
  end
endmodule

// File: rtl/txcsum_insert.sv
module txcsum_insert
  import txcsum_pkg::*;
#(
  parameter int MAX_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_enable,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_first_seg,
  input  logic       in_csum_req,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       err
);
  localparam int AW = $clog2(MAX_BYTES);
  localparam int LW = AW + 1;
  localparam int CW = ((LW > OFS_BITS) ? LW : OFS_BITS) + 2;

  txcsum_state_e st;
  logic          mode;
  logic [31:0]   ctrl;
  logic [1:0]    cnt;
  logic [AW-1:0] wptr;
  logic [LW-1:0] len;
  logic [LW-1:0] rptr;
  logic          patch_en;
  logic [OFS_BITS-1:0] patch_loc;
  logic [15:0]   patch_val;
  logic          err_r;
  logic          rd_v1, rd_first1, rd_last1, rd_hi1, rd_lo1;
  logic [7:0]    rdata;
  logic [15:0]   sum;

  logic in_fire, mode_now, we, acc_add, acc_clr, acc_upper, rd_en, rd_last, ofs_ok;
  logic [OFS_BITS-1:0] start_ofs, ins_ofs;
  logic [CW-1:0] start_c, ins_c, len_c, wptr_c;

  assign in_ready  = (st == ST_IDLE) || (st == ST_CTRL) || (st == ST_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign mode_now  = cfg_enable && in_first_seg && in_csum_req;
  assign start_ofs = ctrl[OFS_BITS-1:0];
  assign ins_ofs   = ctrl[16 +: OFS_BITS];
  assign start_c   = CW'(start_ofs);
  assign ins_c     = CW'(ins_ofs);
  assign len_c     = CW'(len);
  assign wptr_c    = CW'(wptr);

  always_comb begin
    we        = in_fire && (((st == ST_IDLE) && in_sop && !mode_now) || (st == ST_LOAD));
    acc_clr   = in_fire && (st == ST_IDLE) && in_sop;
    acc_add   = in_fire && (st == ST_LOAD) && mode && (wptr_c >= start_c);
    acc_upper = (wptr[0] == start_ofs[0]);
    rd_en     = (st == ST_EMIT);
    rd_last   = (rptr == len - LW'(1));
    ofs_ok    = mode
             && (start_c >= CW'(HDR_BYTES)) && (start_c + CW'(TAIL_BYTES + 1) <= len_c)
             && (ins_c   >= CW'(HDR_BYTES)) && (ins_c   + CW'(TAIL_BYTES + 2) <= len_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode      <= 1'b0;
      ctrl      <= '0;
      cnt       <= '0;
      wptr      <= '0;
      len       <= '0;
      rptr      <= '0;
      patch_en  <= 1'b0;
      patch_loc <= '0;
      patch_val <= '0;
      err_r     <= 1'b0;
    end else begin
      err_r <= 1'b0;
      case (st)
        ST_IDLE: begin
          wptr <= '0;
          if (in_fire && in_sop) begin
            mode <= mode_now;
            if (mode_now) begin
              ctrl[7:0] <= in_data;
              cnt       <= 2'd1;
              st        <= ST_CTRL;
            end else if (in_eop) begin
              len <= LW'(1);
              st  <= ST_CHECK;
            end else begin
              wptr <= AW'(1);
              st   <= ST_LOAD;
            end
          end
        end
        ST_CTRL: begin
          if (in_fire) begin
            ctrl[cnt*8 +: 8] <= in_data;
            cnt <= cnt + 2'd1;
            if (cnt == 2'd3) st <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_fire) begin
            wptr <= wptr + AW'(1);
            if (in_eop) begin
              len <= LW'(wptr) + LW'(1);
              st  <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          patch_en  <= ofs_ok;
          patch_loc <= ins_ofs;
          patch_val <= ~sum;
          err_r     <= mode && !ofs_ok;
          rptr      <= '0;
          wptr      <= '0;
          st        <= ST_EMIT;
        end
        ST_EMIT: begin
          rptr <= rptr + LW'(1);
          if (rd_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1     <= 1'b0;
      rd_first1 <= 1'b0;
      rd_last1  <= 1'b0;
      rd_hi1    <= 1'b0;
      rd_lo1    <= 1'b0;
    end else begin
      rd_v1     <= rd_en;
      rd_first1 <= rd_en && (rptr == '0);
      rd_last1  <= rd_en && rd_last;
      rd_hi1    <= rd_en && patch_en && (CW'(rptr) == CW'(patch_loc));
      rd_lo1    <= rd_en && patch_en && (CW'(rptr) == CW'(patch_loc) + CW'(1));
    end
  end

  txcsum_store #(.DEPTH(MAX_BYTES), .AW(AW)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (wptr),
    .wdata (in_data),
    .re    (rd_en),
    .raddr (rptr[AW-1:0]),
    .rdata (rdata)
  );

  txcsum_accum u_accum (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc_clr),
    .add     (acc_add),
    .upper   (acc_upper),
    .byte_in (in_data),
    .sum     (sum)
  );

  txcsum_outstage u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_v      (rd_v1),
    .rd_first  (rd_first1),
    .rd_last   (rd_last1),
    .rd_hi     (rd_hi1),
    .rd_lo     (rd_lo1),
    .rdata     (rdata),
    .pval      (patch_val),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
  );

  assign err = err_r;
endmodule

// File: rtl/txcsum_insert_chk.sv
module txcsum_insert_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_eop,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop,
  input logic err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !err && in_ready));

  assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_stall_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eop) |=> !in_ready);

  assert_sop_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);

  assert_eop_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> out_valid);

  assert_no_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> out_valid);

  assert_idle_after_frame_R9: assert property (@(posedge clk) disable iff (rst)
    out_eop |=> !out_valid);

  assert_first_has_sop_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sop);
endmodule

bind txcsum_insert txcsum_insert_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .err       (err)
);

// File: tb/txcsum_insert_bench.sv
`timescale 1ns/1ps
module txcsum_insert_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_sop = 1'b0, in_eop = 1'b0, in_first_seg = 1'b0, in_csum_req = 1'b0;
  logic out_valid, out_sop, out_eop, err;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  txcsum_insert u_txcsum_insert (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_first_seg(in_first_seg),
    .in_csum_req(in_csum_req),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int err_seen = 0;
  int out_idx = 0;
  bit loading = 0;
  bit done = 0;
  string cur_tag = "R1";
  logic [7:0] frm [$];
  logic [7:0] exp_q [$];
  logic [7:0] last_out [2048];

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (err) err_seen++;
      if (out_valid) begin
        check("R9", !loading, 1, 0);
        if (out_sop) out_idx = 0;
        if (out_idx < 2048) last_out[out_idx] = out_data;
        if (exp_q.size() == 0) begin
          check(cur_tag, 1'b0, out_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cur_tag, out_data == e, out_data, e);
          check("R9", out_sop == (out_idx == 0), out_sop, out_idx == 0);
          check("R9", out_eop == (exp_q.size() == 0), out_eop, exp_q.size() == 0);
        end
        out_idx++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input bit s, input bit e, input bit f, input bit r);
    in_valid = 1; in_data = b; in_sop = s; in_eop = e; in_first_seg = f; in_csum_req = r;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  // Sends frm[] as one packet and queues the expected output.
  task automatic run_frame(input string tag, input bit en, input bit f, input bit r,
                           input logic [31:0] ctl);
    int n, s, l, sum;
    bit mode, ok;
    int err0;
    n = frm.size();
    mode = en && f && r;
    s = int'(ctl[11:0]);
    l = int'(ctl[27:16]);
    ok = mode && s >= 14 && s + 5 <= n && l >= 14 && l + 6 <= n;
    sum = 0;
    for (int i = s; i < n; i += 2) begin
      sum += {frm[i], (i + 1 < n) ? frm[i+1] : 8'h00};
      sum = (sum & 16'hffff) + (sum >> 16);
    end
    sum = (~sum) & 16'hffff;
    for (int i = 0; i < n; i++) begin
      if (ok && i == l)          exp_q.push_back(sum[15:8]);
      else if (ok && i == l + 1) exp_q.push_back(sum[7:0]);
      else                       exp_q.push_back(frm[i]);
    end
    cur_tag = tag;
    err0 = err_seen;
    cfg_enable = en;
    loading = 1;
    if (mode) begin
      for (int k = 0; k < 4; k++) push(ctl[k*8 +: 8], k == 0, 0, f, r);
      for (int i = 0; i < n; i++) push(frm[i], 0, i == n - 1, f, r);
    end else begin
      for (int i = 0; i < n; i++) push(frm[i], i == 0, i == n - 1, f, r);
    end
    loading = 0;
    check("R9", in_ready == 0, in_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(mode && !ok ? "R8" : tag, (err_seen - err0) == ((mode && !ok) ? 1 : 0),
          err_seen - err0, (mode && !ok) ? 1 : 0);
  endtask

  task automatic fill(input int n, input int seed);
    frm.delete();
    for (int i = 0; i < n; i++) frm.push_back(8'((i * seed + 3 * seed + i / 7) & 255));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", out_valid == 0, out_valid, 0);
    check("R1", err == 0, err, 0);
    check("R1", in_ready == 1, in_ready, 1);
    rst = 0;
    @(negedge clk);

    fill(30, 5);  run_frame("R2", 1, 1, 0, 32'h0010_0010);
    fill(30, 11); run_frame("R3", 0, 1, 1, 32'h0010_0010);
    fill(30, 13); run_frame("R3", 1, 0, 1, 32'h0010_0010);

    // Hand-computed case: only bytes 14,15 nonzero (0x12,0x34) -> inverse 0xEDCB.
    frm.delete();
    for (int i = 0; i < 24; i++) frm.push_back(8'h00);
    frm[14] = 8'h12; frm[15] = 8'h34;
    run_frame("R4", 1, 1, 1, 32'h0010_000E);
    check("R6", last_out[16] == 8'hED, last_out[16], 8'hED);
    check("R6", last_out[17] == 8'hCB, last_out[17], 8'hCB);
    check("R4", last_out[0] == 8'h00, last_out[0], 8'h00);

    // Unused control bits set: same result.
    run_frame("R4", 1, 1, 1, 32'hF010_F00E);
    check("R4", last_out[16] == 8'hED, last_out[16], 8'hED);

    fill(61, 7);  run_frame("R5", 1, 1, 1, 32'h0014_000F);
    fill(40, 9);  run_frame("R7", 1, 1, 1, 32'h0018_000E);
    fill(64, 3);  run_frame("R6", 1, 1, 1, 32'h000E_001E);
    fill(40, 17); run_frame("R8", 1, 1, 1, 32'h0014_000D);
    fill(40, 19); run_frame("R8", 1, 1, 1, 32'h0014_0024);
    fill(40, 23); run_frame("R8", 1, 1, 1, 32'h0023_0014);
    fill(40, 29); run_frame("R8", 1, 1, 1, 32'h000D_0014);
    fill(40, 31); run_frame("R8", 1, 1, 1, 32'h0022_0023);
    fill(2048, 37); run_frame("R10", 1, 1, 1, 32'h0028_0064);
    fill(2048, 41); run_frame("R10", 1, 1, 0, 32'h0028_0064);

    check("R9", exp_q.size() == 0, exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule